// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is one channel of a serial peripheral's data mover. It moves single bytes between system memory and one direction of a serial peripheral: memory to a transmitter, or a receiver to memory. A parameter picks the direction. Software loads a start pointer and a byte count. The channel then issues one byte transfer each time the peripheral raises its ready flag, and it keeps doing so until the count runs out.

A second pointer/count pair can be loaded while a block is still moving. When the active count runs out, the channel moves straight on to that second block with no gap. A status line stays high whenever the active count is zero, and that includes the idle state. Gated by a software enable, this line drives the peripheral's interrupt.

The channel registers sit at a fixed offset inside the host peripheral's register window. The memory side is a simple request port with a fixed one-cycle read latency. The peripheral side is a byte strobe paired with the peripheral's ready flag.

Top module: `periph_dma_chan`

## Requirements
- R1: After reset the pointer, count, next pointer and next count all read 0, the interrupt enable is 0, `end_flag` is 1 and `irq` is 0.
- R2: The registers are word aligned at offset 0x100 of the peripheral window: pointer at +0x00, count at +0x04 (16 bits, upper write bits dropped), next pointer at +0x08, next count at +0x0C, and control at +0x10 (bit 0 = interrupt enable). Reads return the live values. Any other address reads 0, and writes to any other address change nothing.
- R3: A byte transfer is issued only in a cycle where `per_ready` is 1, the count is non-zero and no register write is taking place. Each transfer increments the pointer by 1 and decrements the count by 1.
- R4: At most one transfer is issued per high period of `per_ready`. `per_ready` must be sampled low before the next transfer. The state just after reset counts as having seen it low.
- R5: If the count is written non-zero while `per_ready` is high and the channel is armed, the first transfer (`mem_req`) is issued in the cycle right after the write.
- R6: In the transmit direction (TO_PERIPH=1), a transfer reads memory at the pointer (`mem_we`=0). `per_strobe` pulses in the next cycle, carrying that byte on `per_wdata`.
- R7: In the receive direction (TO_PERIPH=0), a transfer writes `per_rdata` into memory at the pointer (`mem_we`=1), and `per_strobe` pulses in the same cycle.
- R8: If the transfer that drops the count to zero finds a non-zero next count, the pointer takes the next pointer, the count takes the next count and the next count clears to 0. `end_flag` stays low across this change.
- R9: If the next count is 0 when the active count expires, the channel stops and issues no further transfers.
- R10: `end_flag` is 1 exactly while the active count is 0, and `irq` equals `end_flag` AND the interrupt enable.
- R11: Writing the count while a block is in progress replaces the remaining count. Transfers then continue from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | PAW | Byte address within the peripheral window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, one per transfer |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |
| per_ready | input | 1 | Peripheral ready flag that paces the transfers |
| per_strobe | output | 1 | Byte push to, or pop from, the peripheral |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte received from the peripheral |
| end_flag | output | 1 | High while the active count is zero |
| irq | output | 1 | End flag gated by the interrupt enable |

## Verification
The transmit channel runs a table of blocks with different start pointers and lengths, from one byte up to sixteen. This shows that the count limits the stream exactly and that each byte comes from the right address. A receiver driven by hand holds ready high for many cycles and then gives short pulses. This separates "one transfer per ready assertion" from "one transfer per cycle". A chained pair of blocks is checked for an unbroken byte stream with no end flag between the blocks, and for a clean stop afterwards. Directed cases cover the start cycle after a count write, a count overwrite in mid-block, and the interrupt gating.

// File: rtl/periph_dma_chan.sv
module periph_dma_chan #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int PAW       = 12,
  parameter int CHAN_OFS  = 'h100,
  parameter bit TO_PERIPH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [PAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              per_ready,
  output logic              per_strobe,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata,
  output logic              end_flag,
  output logic              irq
);
  localparam logic [PAW-1:0] OFS = PAW'(CHAN_OFS);

  logic [ADDR_W-1:0] ptr, nptr;
  logic [CNT_W-1:0]  cnt, ncnt;
  logic              ie, armed, pend;

  wire       hit = (reg_addr[PAW-1:5] == OFS[PAW-1:5]) && (reg_addr[1:0] == 2'b00);
  wire [2:0] idx = reg_addr[4:2];
  wire       wr  = reg_we && hit;

  wire go    = per_ready && armed && (cnt != '0) && !pend && !reg_we;
  wire chain = go && (cnt == CNT_W'(1)) && (ncnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      cnt   <= '0;
      nptr  <= '0;
      ncnt  <= '0;
      ie    <= 1'b0;
      armed <= 1'b1;
      pend  <= 1'b0;
    end else begin
      if (!per_ready) armed <= 1'b1;
      else if (go)    armed <= 1'b0;
      pend <= go && TO_PERIPH;
      if (chain) begin
        ptr  <= nptr;
        cnt  <= ncnt;
        ncnt <= '0;
      end else if (go) begin
        ptr <= ptr + 1'b1;
        cnt <= cnt - 1'b1;
      end
      if (wr && idx == 3'd0) ptr  <= reg_wdata[ADDR_W-1:0];
      if (wr && idx == 3'd1) cnt  <= reg_wdata[CNT_W-1:0];
      if (wr && idx == 3'd2) nptr <= reg_wdata[ADDR_W-1:0];
      if (wr && idx == 3'd3) ncnt <= reg_wdata[CNT_W-1:0];
      if (wr && idx == 3'd4) ie   <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (idx)
        3'd0:    reg_rdata = 32'(ptr);
        3'd1:    reg_rdata = 32'(cnt);
        3'd2:    reg_rdata = 32'(nptr);
        3'd3:    reg_rdata = 32'(ncnt);
        3'd4:    reg_rdata = {31'd0, ie};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign mem_req   = go;
  assign mem_we    = !TO_PERIPH;
  assign mem_addr  = ptr;
  assign mem_wdata = per_rdata;
  assign per_wdata = mem_rdata;
  assign end_flag  = (cnt == '0);
  assign irq       = end_flag && ie;

  generate
    if (TO_PERIPH) begin : g_tx
      assign per_strobe = pend;
    end else begin : g_rx
      assign per_strobe = go;
    end
  endgenerate
endmodule

// File: rtl/periph_dma_chan_chk.sv
module periph_dma_chan_chk #(
  parameter bit TO_PERIPH = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic mem_req,
  input logic per_ready,
  input logic per_strobe,
  input logic end_flag,
  input logic irq
);
  assert_req_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (per_ready && !end_flag));

  assert_one_per_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_end_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> ($past(mem_req) || $past(reg_we)));

  assert_end_fall_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_flag) |-> $past(reg_we));

  assert_irq_only_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> end_flag);

  generate
    if (TO_PERIPH) begin : g_tx
      assert_push_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> per_strobe);
      assert_push_has_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_strobe |-> $past(mem_req));
    end else begin : g_rx
      assert_pop_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        per_strobe |-> mem_req);
      assert_write_with_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> per_strobe);
    end
  endgenerate
endmodule

bind periph_dma_chan periph_dma_chan_chk #(.TO_PERIPH(TO_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req),
  .per_ready(per_ready), .per_strobe(per_strobe), .end_flag(end_flag), .irq(irq)
);

// File: tb/periph_dma_chan_tb.sv
`timescale 1ns/1ps
module periph_dma_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        tx_we = 1'b0, rx_we = 1'b0;
  logic [31:0] tx_rd, rx_rd;

  logic        tx_req, tx_mwe, tx_strobe, tx_end, tx_irq;
  logic [31:0] tx_addr;
  logic [7:0]  tx_mwdata, tx_mrdata = '0, tx_pwdata;
  logic        tx_ready;
  int          tx_busy;

  logic        rx_req, rx_mwe, rx_strobe, rx_end, rx_irq;
  logic [31:0] rx_addr;
  logic [7:0]  rx_mwdata, rx_pwdata, rx_data = '0;
  logic        rx_ready = 1'b0;

  periph_dma_chan #(.TO_PERIPH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(tx_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(tx_rd), .mem_req(tx_req), .mem_we(tx_mwe), .mem_addr(tx_addr),
    .mem_wdata(tx_mwdata), .mem_rdata(tx_mrdata), .per_ready(tx_ready),
    .per_strobe(tx_strobe), .per_wdata(tx_pwdata), .per_rdata(8'h00),
    .end_flag(tx_end), .irq(tx_irq));

  periph_dma_chan #(.TO_PERIPH(1'b0)) u_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(rx_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rx_rd), .mem_req(rx_req), .mem_we(rx_mwe), .mem_addr(rx_addr),
    .mem_wdata(rx_mwdata), .mem_rdata(8'h00), .per_ready(rx_ready),
    .per_strobe(rx_strobe), .per_wdata(rx_pwdata), .per_rdata(rx_data),
    .end_flag(rx_end), .irq(rx_irq));

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a[7:0] * 7 + 3);
  endfunction

  logic [7:0] tx_log [0:255];
  int         tx_n = 0;
  logic [7:0] rx_mem [0:255];
  int         rx_n = 0;

  always @(posedge clk) begin
    if (tx_req && !tx_mwe) tx_mrdata <= pat(tx_addr);
    if (tx_strobe) begin
      tx_log[tx_n[7:0]] <= tx_pwdata;
      tx_n <= tx_n + 1;
    end
    if (rx_req && rx_mwe) begin
      rx_mem[rx_addr[7:0]] <= rx_mwdata;
      rx_n <= rx_n + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      tx_ready <= 1'b1;
      tx_busy  <= 0;
    end else if (tx_strobe) begin
      tx_ready <= 1'b0;
      tx_busy  <= 3;
    end else if (tx_busy != 0) begin
      tx_busy <= tx_busy - 1;
      if (tx_busy == 1) tx_ready <= 1'b1;
    end
  end

  int total = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit rx, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d;
    if (rx) rx_we = 1'b1; else tx_we = 1'b1;
    @(negedge clk);
    rx_we = 1'b0; tx_we = 1'b0;
  endtask

  task automatic rd(input bit rx, input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = rx ? rx_rd : tx_rd;
  endtask

  task automatic wait_tx(input int n);
    int t = 0;
    while (tx_n < n && t < 600) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_rx(input logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [15:0] VEC [0:3] = '{16'h1001, 16'h2005, 16'hF003, 16'h4010};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, bad, rn, gap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, 12'h100, v); chk(v == 0, "R1 ptr", v, 0);
    rd(0, 12'h104, v); chk(v == 0, "R1 cnt", v, 0);
    rd(0, 12'h10C, v); chk(v == 0, "R1 ncnt", v, 0);
    rd(0, 12'h110, v); chk(v == 0, "R1 ctl", v, 0);
    chk(tx_end == 1'b1 && tx_irq == 1'b0, "R1 end/irq", {tx_end, tx_irq}, 2'b10);

    wr(0, 12'h108, 32'h0000_1234);
    rd(0, 12'h108, v); chk(v == 32'h1234, "R2 nptr readback", v, 32'h1234);
    rd(0, 12'h114, v); chk(v == 0, "R2 unmapped read", v, 0);
    wr(0, 12'h004, 32'd5);
    rd(0, 12'h104, v); chk(v == 0 && tx_n == 0, "R2 outside write ignored", v, 0);
    wr(1, 12'h104, 32'h0001_2345);
    rd(1, 12'h104, v); chk(v == 32'h2345, "R2 count width 16", v, 32'h2345);
    wr(1, 12'h104, 32'd0);
    wr(0, 12'h108, 32'd0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] p, c;
      p = VEC[i][15:8]; c = VEC[i][7:0];
      base = tx_n;
      wr(0, 12'h100, 32'(p));
      wr(0, 12'h104, 32'(c));
      wait_tx(base + c);
      chk(tx_n - base == c, "R3 bytes sent", tx_n - base, 32'(c));
      bad = 0;
      for (int k = 0; k < c; k++)
        if (tx_log[8'(base + k)] != pat(32'(p + 8'(k)))) bad++;
      chk(bad == 0, "R6 byte values", bad, 0);
      rd(0, 12'h100, v); chk(v == 32'(p) + 32'(c), "R3 final pointer", v, 32'(p) + 32'(c));
      chk(tx_end == 1'b1, "R10 end after block", tx_end, 1);
    end

    wr(0, 12'h100, 32'h50);
    wr(0, 12'h104, 32'd1);
    #1 chk(tx_req == 1'b1, "R5 start next cycle", tx_req, 1);
    wait_tx(tx_n + 1);

    base = tx_n;
    wr(0, 12'h108, 32'h90);
    wr(0, 12'h10C, 32'd3);
    wr(0, 12'h100, 32'h60);
    wr(0, 12'h104, 32'd2);
    gap = 0;
    for (int t = 0; t < 600 && tx_n < base + 3; t++) begin
      if (tx_end) gap++;
      @(negedge clk);
    end
    chk(gap == 0, "R8 no end between blocks", gap, 0);
    wait_tx(base + 5);
    repeat (20) @(negedge clk);
    chk(tx_n - base == 5, "R9 stop after chain", tx_n - base, 5);
    bad = 0;
    if (tx_log[8'(base)]   != pat(32'h60)) bad++;
    if (tx_log[8'(base+1)] != pat(32'h61)) bad++;
    if (tx_log[8'(base+2)] != pat(32'h90)) bad++;
    if (tx_log[8'(base+3)] != pat(32'h91)) bad++;
    if (tx_log[8'(base+4)] != pat(32'h92)) bad++;
    chk(bad == 0, "R8 chained byte order", bad, 0);
    rd(0, 12'h10C, v); chk(v == 0, "R8 next count cleared", v, 0);
    rd(0, 12'h100, v); chk(v == 32'h93, "R9 pointer after chain", v, 32'h93);

    wr(0, 12'h110, 32'd1);
    #1 chk(tx_irq == 1'b1, "R10 irq enabled idle", tx_irq, 1);
    wr(0, 12'h100, 32'h30);
    wr(0, 12'h104, 32'd2);
    #1 chk(tx_irq == 1'b0 && tx_end == 1'b0, "R10 irq low while busy", {tx_end, tx_irq}, 0);
    wait_tx(tx_n + 2);
    chk(tx_irq == 1'b1, "R10 irq at end", tx_irq, 1);
    wr(0, 12'h110, 32'd0);
    #1 chk(tx_irq == 1'b0, "R10 irq masked", tx_irq, 0);

    wr(1, 12'h100, 32'h80);
    wr(1, 12'h104, 32'd3);
    rn = rx_n;
    @(negedge clk);
    rx_data = 8'hA5; rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_n - rn == 1, "R4 one per ready level", rx_n - rn, 1);
    rx_ready = 1'b0;
    rd(1, 12'h104, v); chk(v == 2, "R3 count decrement", v, 2);
    chk(rx_mem[8'h80] == 8'hA5, "R7 received byte", rx_mem[8'h80], 8'hA5);
    pulse_rx(8'h3C);
    chk(rx_n - rn == 2, "R4 re-armed by low", rx_n - rn, 2);
    chk(rx_mem[8'h81] == 8'h3C, "R7 second byte", rx_mem[8'h81], 8'h3C);
    rd(1, 12'h100, v); chk(v == 32'h82, "R3 pointer increment", v, 32'h82);

    wr(1, 12'h104, 32'd4);
    rd(1, 12'h104, v); chk(v == 4, "R11 count replaced", v, 4);
    for (int k = 0; k < 4; k++) pulse_rx(8'(k + 1));
    chk(rx_end == 1'b1, "R11 end after new count", rx_end, 1);
    rd(1, 12'h100, v); chk(v == 32'h86, "R11 pointer continued", v, 32'h86);
    rn = rx_n;
    pulse_rx(8'hEE);
    chk(rx_n == rn, "R3 no transfer at zero count", rx_n - rn, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule